// File: doc/BRIEF.md
# Burst SRAM Access Sequencer

This block is the clocked front end of a pipelined burst static RAM. On each rising clock edge it takes in the address, three chip selects, two address strobes, a burst-advance strobe and per-byte write enables. It classifies the cycle as one of four kinds: a deselect, a new burst, a burst step or a burst pause. It then presents one registered internal access to the memory array: the array address, a write flag, the byte enables and a valid flag.

Either strobe can open a burst. The processor strobe has priority, always reads, and is blocked while the primary select is high. This lets a pipelining processor put the next address on the bus early without starting a cycle. The controller strobe reads or writes according to the byte enables.

Within a burst, the two low address bits come from a 2-bit counter XORed onto the starting low bits, which gives interleaved order. The upper address bits are held for the whole burst, and the external address is ignored until the next start.

Top module: `burst_seq_top`

## Requirements
- R1: While reset is asserted and after it is released, the outputs show no access: valid 0, write 0, byte enables 00, address 0.
- R2: A start is a processor strobe (`adsp_n_i` low with `cs_n_i` low) or a controller strobe (`adsc_n_i` low). A start while fully selected (`cs_n_i` low, `cs2_i` high, `cs2_n_i` low) makes the outputs after that edge show a valid access at the sampled address.
- R3: While `cs_n_i` is high, a low `adsp_n_i` has no effect. The cycle is decided by the remaining strobes as if `adsp_n_i` were high.
- R4: A start while any chip select is inactive is a deselect, even if write enables are low. Valid falls after that edge and stays low through later step or pause cycles until a new selected start.
- R5: With no start, a live burst and `adv_n_i` low, the access moves to the next address of the burst.
- R6: The low two address bits equal the starting low bits XOR a counter that begins at 0 and counts up by one per step. This gives the orders 00,01,10,11 / 01,00,11,10 / 10,11,00,01 / 11,10,01,00. After four accesses the sequence wraps to the start. Bits above bit 1 stay fixed for the burst.
- R7: With no start, a live burst and `adv_n_i` high, the same address is accessed again.
- R8: A processor-strobe start is always a read. A controller-strobe start, a step and a pause are writes when any bit of `we_n_i` is low and reads otherwise.
- R9: `acc_be_o[i]` is 1 on a write when `we_n_i[i]` is low, where bit 0 is the lower byte. A read shows 11 and no access shows 00.
- R10: When both strobes are low and the chip is selected, the processor strobe wins and the cycle is a read.
- R11: During step and pause cycles the address inputs have no effect on the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External address |
| cs_n_i | input | 1 | Primary chip select, active low, also gates the processor strobe |
| cs2_i | input | 1 | Secondary chip select, active high |
| cs2_n_i | input | 1 | Secondary chip select, active low |
| adsp_n_i | input | 1 | Processor address strobe, active low |
| adsc_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| we_n_i | input | NBYTE | Byte write enables, active low |
| acc_valid_o | output | 1 | Access valid this cycle |
| acc_write_o | output | 1 | Access is a write |
| acc_be_o | output | NBYTE | Byte enables of the access |
| acc_addr_o | output | ADDR_W | Array address of the access |

## Verification
A corrupted burst counter or held upper address shows up on `acc_addr_o` in the first cycle after the faulty step. Every step is checked against an arithmetic start-XOR-count model, so a wrong interleave or a missing wrap is seen within four cycles of a start. A stale burst-live flag shows as a valid access after a deselect, visible one edge later. Wrong strobe priority or gating shows at once as a wrong write flag, wrong byte enables or a wrong address.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_START = 2'd1,
        OP_NEXT  = 2'd2,
        OP_HOLD  = 2'd3
    } op_e;
endpackage

// File: rtl/burst_seq_decode.sv
module burst_seq_decode
    import burst_seq_pkg::*;
#(
    parameter int NBYTE = 2
) (
    input  logic             cs_n,
    input  logic             cs2,
    input  logic             cs2_n,
    input  logic             adsp_n,
    input  logic             adsc_n,
    input  logic             adv_n,
    input  logic [NBYTE-1:0] we_n,
    input  logic             live,
    output op_e              op,
    output logic             valid,
    output logic             wr,
    output logic [NBYTE-1:0] be
);
    logic sel;
    logic p_req;
    logic c_req;
    logic any_we;

    always_comb begin
        sel    = !cs_n && cs2 && !cs2_n;
        p_req  = !adsp_n && !cs_n;      // processor strobe blocked by primary select
        c_req  = !adsc_n;
        any_we = |(~we_n);
        op     = OP_IDLE;
        valid  = 1'b0;
        wr     = 1'b0;
        if (p_req || c_req) begin
            if (sel) begin
                op    = OP_START;
                valid = 1'b1;
                wr    = p_req ? 1'b0 : any_we;
            end
        end else if (live) begin
            op    = adv_n ? OP_HOLD : OP_NEXT;
            valid = 1'b1;
            wr    = any_we;
        end
        if (!valid)   be = '0;
        else if (wr)  be = ~we_n;
        else          be = '1;
    end
endmodule

// File: rtl/burst_seq_ctr.sv
module burst_seq_ctr
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] acc_addr
);
    localparam int UPPER_W = ADDR_W - CNT_W;

    typedef struct packed {
        logic [UPPER_W-1:0] upper;
        logic [CNT_W-1:0]   start;
        logic [CNT_W-1:0]   cnt;
    } ctr_s;

    ctr_s ctr_d;
    ctr_s ctr_q;
    logic [CNT_W-1:0] lo_w;

    always_comb begin
        ctr_d = ctr_q;
        case (op)
            OP_START: begin
                ctr_d.upper = addr[ADDR_W-1:CNT_W];
                ctr_d.start = addr[CNT_W-1:0];
                ctr_d.cnt   = '0;
            end
            OP_NEXT:  ctr_d.cnt = ctr_q.cnt + 1'b1;
            default:  ctr_d = ctr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign lo_w     = ctr_q.start ^ ctr_q.cnt;
    assign acc_addr = {ctr_q.upper, lo_w};

    // R5
    step_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NEXT) |=> (lo_w != $past(lo_w)) && $stable(ctr_q.upper));

    // R7
    pause_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(acc_addr));
endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NBYTE  = 2,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cs_n_i,
    input  logic              cs2_i,
    input  logic              cs2_n_i,
    input  logic              adsp_n_i,
    input  logic              adsc_n_i,
    input  logic              adv_n_i,
    input  logic [NBYTE-1:0]  we_n_i,
    output logic              acc_valid_o,
    output logic              acc_write_o,
    output logic [NBYTE-1:0]  acc_be_o,
    output logic [ADDR_W-1:0] acc_addr_o
);
    typedef struct packed {
        logic             live;
        logic             valid;
        logic             wr;
        logic [NBYTE-1:0] be;
    } acc_s;

    acc_s acc_d;
    acc_s acc_q;

    op_e              op_w;
    logic             valid_w;
    logic             wr_w;
    logic [NBYTE-1:0] be_w;

    burst_seq_decode #(.NBYTE(NBYTE)) u_decode (
        .cs_n   (cs_n_i),
        .cs2    (cs2_i),
        .cs2_n  (cs2_n_i),
        .adsp_n (adsp_n_i),
        .adsc_n (adsc_n_i),
        .adv_n  (adv_n_i),
        .we_n   (we_n_i),
        .live   (acc_q.live),
        .op     (op_w),
        .valid  (valid_w),
        .wr     (wr_w),
        .be     (be_w)
    );

    burst_seq_ctr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op_w),
        .addr     (addr_i),
        .acc_addr (acc_addr_o)
    );

    always_comb begin
        acc_d       = acc_q;
        acc_d.live  = (op_w != OP_IDLE);
        acc_d.valid = valid_w;
        acc_d.wr    = wr_w;
        acc_d.be    = be_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc_valid_o = acc_q.valid;
    assign acc_write_o = acc_q.wr;
    assign acc_be_o    = acc_q.be;

    // R8
    psd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n_i && !cs_n_i && cs2_i && !cs2_n_i) |=> (acc_valid_o && !acc_write_o));

    // R4
    desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!adsc_n_i || (!adsp_n_i && !cs_n_i)) && (cs_n_i || !cs2_i || cs2_n_i))
        |=> !acc_valid_o);

    // R9
    write_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_write_o |-> (acc_valid_o && acc_be_o != '0));

    // R6
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_o && adsp_n_i && adsc_n_i)
        |=> $stable(acc_addr_o[ADDR_W-1:CNT_W]));
endmodule

// File: tb/burst_seq_top_test.sv
module burst_seq_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        cs_n = 1'b1, cs2 = 1'b0, cs2_n = 1'b1;
    logic        adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
    logic [1:0]  we_n = 2'b11;
    logic        acc_valid, acc_write;
    logic [1:0]  acc_be;
    logic [15:0] acc_addr;

    logic [13:0] m_up = '0;
    logic [1:0]  m_st = '0, m_cnt = '0, m_be = '0;
    logic        m_live = 1'b0, m_valid = 1'b0, m_wr = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    burst_seq_top uut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .cs_n_i(cs_n), .cs2_i(cs2),
        .cs2_n_i(cs2_n), .adsp_n_i(adsp_n), .adsc_n_i(adsc_n), .adv_n_i(adv_n),
        .we_n_i(we_n), .acc_valid_o(acc_valid), .acc_write_o(acc_write),
        .acc_be_o(acc_be), .acc_addr_o(acc_addr)
    );

    function automatic logic [15:0] exp_addr();
        return {m_up, m_st ^ m_cnt};
    endfunction

    task automatic model();
        logic sel, p, c, anywe;
        sel = !cs_n && cs2 && !cs2_n;
        p = !adsp_n && !cs_n;
        c = !adsc_n;
        anywe = (we_n != 2'b11);
        if (p || c) begin
            if (sel) begin
                m_up = addr[15:2]; m_st = addr[1:0]; m_cnt = 2'd0;
                m_live = 1'b1; m_valid = 1'b1; m_wr = p ? 1'b0 : anywe;
            end else begin
                m_live = 1'b0; m_valid = 1'b0; m_wr = 1'b0;
            end
        end else if (m_live) begin
            if (!adv_n) m_cnt = m_cnt + 2'd1;
            m_valid = 1'b1; m_wr = anywe;
        end else begin
            m_valid = 1'b0; m_wr = 1'b0;
        end
        m_be = !m_valid ? 2'b00 : (m_wr ? ~we_n : 2'b11);
    endtask

    task automatic check(input string tag);
        n_chk++;
        if (acc_valid !== m_valid || acc_write !== m_wr || acc_be !== m_be ||
            acc_addr !== exp_addr()) begin
            n_bad++;
            $display("FAIL %s: got v=%b w=%b be=%b a=%h, expected v=%b w=%b be=%b a=%h",
                     tag, acc_valid, acc_write, acc_be, acc_addr,
                     m_valid, m_wr, m_be, exp_addr());
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        model();
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle_strobes();
        adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1; we_n = 2'b11;
    endtask

    task automatic select();
        cs_n = 1'b0; cs2 = 1'b1; cs2_n = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release");

        // R2 R5 R6 R11: every start offset, ADSC read burst, wrap, address bus churn
        select();
        for (int s = 0; s < 4; s++) begin
            idle_strobes();
            adsc_n = 1'b0; addr = 16'h5A50 | 16'(s);
            cyc("R2 start");
            adsc_n = 1'b1; adv_n = 1'b0;
            for (int k = 0; k < 5; k++) begin
                addr = 16'hFFFF ^ 16'(k * 7);
                cyc("R5 R6 R11 interleave");
            end
        end

        // R7 pause
        idle_strobes(); adsc_n = 1'b0; addr = 16'h1232; cyc("R2 start");
        adsc_n = 1'b1; adv_n = 1'b1; addr = 16'h0001; cyc("R7 pause");
        cyc("R7 pause");
        adv_n = 1'b0; cyc("R5 step after pause");

        // R8 R9 every write enable combination via ADSC, then step and pause writes
        for (int w = 0; w < 4; w++) begin
            idle_strobes(); adsc_n = 1'b0; we_n = 2'(w); addr = 16'h4440 + 16'(w);
            cyc("R8 R9 controller start");
            adsc_n = 1'b1; adv_n = 1'b0; cyc("R8 R9 step write");
            adv_n = 1'b1; cyc("R8 R9 pause write");
        end

        // R8 processor start ignores write enables
        idle_strobes(); adsp_n = 1'b0; we_n = 2'b00; addr = 16'h7777; cyc("R8 processor read");

        // R3 processor strobe blocked by primary select inside a live burst
        adsp_n = 1'b0; cs_n = 1'b1; we_n = 2'b11; adv_n = 1'b0; addr = 16'h0000;
        cyc("R3 strobe ignored");
        select();

        // R10 both strobes low
        idle_strobes(); adsp_n = 1'b0; adsc_n = 1'b0; we_n = 2'b00; addr = 16'h2222;
        cyc("R10 priority");

        // R4 deselect with writes asserted, then no access until restart
        idle_strobes(); adsc_n = 1'b0; cs2 = 1'b0; we_n = 2'b00; cyc("R4 deselect");
        adsc_n = 1'b1; adv_n = 1'b0; cyc("R4 stays idle");
        select(); adv_n = 1'b1; cyc("R4 stays idle");
        adsp_n = 1'b0; cs2_n = 1'b1; cyc("R4 deselect processor");
        select();

        // near-exhaustive sweep over every control combination, two orders
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 512; i++) begin
                logic [8:0] v;
                v = pass == 0 ? 9'(i) : 9'(i) ^ 9'h1B5;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                addr = lfsr;
                adsp_n = v[0]; adsc_n = v[1]; adv_n = v[2]; cs_n = v[3] & v[8];
                cs2 = v[4] | v[8]; cs2_n = v[5] & ~v[8]; we_n = v[7:6];
                cyc("R2/R4/R6/R8/R9 sweep");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule